// File: doc/BRIEF.md
# Source Pixel Expander

This block turns a single stored source pixel into a 32-bit alpha-red-green-blue value with eight bits per channel, and can then rewrite the alpha channel. It accepts eleven stored formats. Five are direct color, with packed fields of 1 to 8 bits. Four are indexed through a 256-entry color lookup table (CLUT). Two are alpha-only and take their RGB from a fixed color input. The pixel arrives inside a 32-bit fetched word together with a sub-index that picks which pixel in that word is meant. Word fetching, CLUT loading and buffering all happen outside this block.

The block uses two register stages. In stage 0 it decodes the fields and, for indexed formats only, issues a synchronous CLUT read. In stage 1 it merges the table entry, applies the alpha mode and registers the result. Every format, indexed or not, sees the same latency. Each pixel samples its own configuration inputs along with it, so the format may change from one pixel to the next.

Top module: `pix_expand`

## Requirements
- R1: The color mode codes are 0 ARGB8888, 1 RGB888, 2 RGB565, 3 ARGB1555, 4 ARGB4444, 5 L8, 6 AL44, 7 AL88, 8 L4, 9 A8 and 10 A4. Codes 11 to 15 produce an output with `cfg_err_o`=1 and `pix_o`=0. Valid codes produce `cfg_err_o`=0.
- R2: A direct channel narrower than 8 bits is widened by repeating its top bits in the low bits: 5-bit v gives {v,v[4:2]}, 6-bit v gives {v,v[5:4]}, 4-bit v gives {v,v}, and a 1-bit alpha gives 0x00 or 0xFF. The layouts are RGB565 = R[15:11] G[10:5] B[4:0], ARGB1555 = A[15] R[14:10] G[9:5] B[4:0], ARGB4444 = A[15:12] R[11:8] G[7:4] B[3:0], and ARGB8888 = A[31:24] R[23:16] G[15:8] B[7:0].
- R3: RGB888 (pixel in word bits [23:0]), RGB565, and L8 or L4 with 24-bit CLUT entries yield alpha 0xFF before the alpha mode is applied.
- R4: For L8, AL44, AL88 and L4 only, the block raises `clut_re_o` in the pixel's input cycle, with `clut_addr_o` set to the luminance value (zero-extended for 4-bit luminance). RGB is taken from entry bits [23:0] one cycle later. All other formats leave `clut_re_o` low.
- R5: When `clut_24b_i`=0, L8 and L4 take alpha from entry bits [31:24]. When it is 1, they use 0xFF.
- R6: AL44 places alpha in the high nibble and luminance in the low nibble of a byte. AL88 places luminance in the low byte and alpha in the high byte of a halfword. This memory alpha overrides the CLUT alpha, and a 4-bit alpha is widened to {v,v}.
- R7: A8 and A4 output RGB = `fix_rgb_i` and alpha from memory, with 4-bit alpha widened to {v,v}.
- R8: After expansion, alpha mode 0 keeps the alpha, mode 1 replaces it with `fix_alpha_i`, mode 2 replaces it with floor(alpha*`fix_alpha_i`/255), and reserved mode 3 keeps it.
- R9: The sub-index picks the pixel inside the word: bit 0 picks the halfword (1 means [31:16]) for 16-bit formats, bits [1:0] pick the byte for 8-bit formats, and bits [2:0] pick the nibble for 4-bit formats, with nibble k at [4k+3:4k]. 32-bit and 24-bit formats ignore it.
- R10: A pixel accepted at clock edge k appears with `out_valid_o`=1 after edge k+2, whatever its format. Back-to-back pixels come out back-to-back, and `out_valid_o` never rises without a matching input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A pixel is presented this cycle |
| word_i | input | 32 | Fetched memory word |
| sub_i | input | 3 | Pixel position inside the word |
| cmode_i | input | 4 | Stored color mode |
| amode_i | input | 2 | Alpha mode |
| fix_alpha_i | input | 8 | Fixed alpha value |
| fix_rgb_i | input | 24 | Fixed RGB for the alpha-only formats |
| clut_24b_i | input | 1 | CLUT entries are 24-bit RGB |
| clut_re_o | output | 1 | CLUT read enable |
| clut_addr_o | output | 8 | CLUT read index |
| clut_data_i | input | 32 | CLUT entry, one cycle after the read |
| out_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 32 | Expanded ARGB8888 pixel |
| cfg_err_o | output | 1 | Invalid color mode for this output |

## Verification
On every cycle, the assertions check the valid pipeline from input to stage 1 to output. They also check that an error output is zero, that alpha-less formats in keep mode come out opaque, that the fixed alpha mode reproduces the programmed value, and that scaled alpha never exceeds the fixed alpha. Only the bench's scenarios can show the exact channel values. That covers bit replication, sub-index field selection, CLUT index and entry merging, memory alpha overriding the table, the fixed color for alpha-only formats, and the floor of the scaling. For these, every output is compared with a behavioural model over directed corner cases and a long random run with changing formats.

// File: rtl/pix_pkg.sv
package pix_pkg;
  localparam int CH_W   = 8;
  localparam int PIX_W  = 4 * CH_W;
  localparam int CLUT_AW = 8;

  typedef enum logic [3:0] {
    CM_ARGB8888 = 4'd0, CM_RGB888 = 4'd1, CM_RGB565 = 4'd2, CM_ARGB1555 = 4'd3,
    CM_ARGB4444 = 4'd4, CM_L8 = 4'd5, CM_AL44 = 4'd6, CM_AL88 = 4'd7,
    CM_L4 = 4'd8, CM_A8 = 4'd9, CM_A4 = 4'd10
  } cmode_e;

  typedef enum logic [1:0] {AM_KEEP = 2'd0, AM_FIXED = 2'd1, AM_SCALE = 2'd2, AM_RSVD = 2'd3} amode_e;

  typedef struct packed {
    logic [CH_W-1:0] a;
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } argb_t;

  function automatic logic [7:0] wid5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction
  function automatic logic [7:0] wid6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction
  function automatic logic [7:0] wid4(input logic [3:0] v);
    return {v, v};
  endfunction
  function automatic logic [7:0] wid1(input logic v);
    return {8{v}};
  endfunction
endpackage

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_pkg::*;
(
  input  logic [PIX_W-1:0]   word_i,
  input  logic [2:0]         sub_i,
  input  logic [3:0]         cmode_i,
  input  logic [CH_W*3-1:0]  fix_rgb_i,
  output argb_t              pix_o,
  output logic               idx_use_o,
  output logic [CLUT_AW-1:0] idx_o,
  output logic               own_alpha_o,
  output logic               no_alpha_o,
  output logic               err_o
);
  logic [15:0] half;
  logic [7:0]  byte_s;
  logic [3:0]  nib;

  assign half   = sub_i[0] ? word_i[31:16] : word_i[15:0];
  assign byte_s = word_i[{sub_i[1:0], 3'b000} +: 8];
  assign nib    = word_i[{sub_i, 2'b00} +: 4];

  always_comb begin
    pix_o       = '0;
    idx_use_o   = 1'b0;
    idx_o       = '0;
    own_alpha_o = 1'b0;
    no_alpha_o  = 1'b0;
    err_o       = 1'b0;
    case (cmode_i)
      CM_ARGB8888: pix_o = word_i;
      CM_RGB888: begin
        pix_o = {8'hff, word_i[23:0]};
        no_alpha_o = 1'b1;
      end
      CM_RGB565: begin
        pix_o = {8'hff, wid5(half[15:11]), wid6(half[10:5]), wid5(half[4:0])};
        no_alpha_o = 1'b1;
      end
      CM_ARGB1555: pix_o = {wid1(half[15]), wid5(half[14:10]), wid5(half[9:5]), wid5(half[4:0])};
      CM_ARGB4444: pix_o = {wid4(half[15:12]), wid4(half[11:8]), wid4(half[7:4]), wid4(half[3:0])};
      CM_L8: begin
        idx_use_o = 1'b1;
        idx_o = byte_s;
        no_alpha_o = 1'b1;
      end
      CM_AL44: begin
        idx_use_o = 1'b1;
        idx_o = {4'd0, byte_s[3:0]};
        own_alpha_o = 1'b1;
        pix_o.a = wid4(byte_s[7:4]);
      end
      CM_AL88: begin
        idx_use_o = 1'b1;
        idx_o = half[7:0];
        own_alpha_o = 1'b1;
        pix_o.a = half[15:8];
      end
      CM_L4: begin
        idx_use_o = 1'b1;
        idx_o = {4'd0, nib};
        no_alpha_o = 1'b1;
      end
      CM_A8:   pix_o = {byte_s, fix_rgb_i};
      CM_A4:   pix_o = {wid4(nib), fix_rgb_i};
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pix_alpha.sv
module pix_alpha
  import pix_pkg::*;
(
  input  argb_t           pix_i,
  input  logic [1:0]      amode_i,
  input  logic [CH_W-1:0] fix_alpha_i,
  output argb_t           pix_o
);
  logic [2*CH_W-1:0] prod;
  assign prod = pix_i.a * fix_alpha_i;

  always_comb begin
    pix_o = pix_i;
    case (amode_i)
      AM_FIXED: pix_o.a = fix_alpha_i;
      AM_SCALE: pix_o.a = CH_W'(prod / 16'd255);
      default:  pix_o.a = pix_i.a;
    endcase
  end
endmodule

// File: rtl/pix_expand.sv
module pix_expand
  import pix_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [PIX_W-1:0]   word_i,
  input  logic [2:0]         sub_i,
  input  logic [3:0]         cmode_i,
  input  logic [1:0]         amode_i,
  input  logic [CH_W-1:0]    fix_alpha_i,
  input  logic [CH_W*3-1:0]  fix_rgb_i,
  input  logic               clut_24b_i,
  output logic               clut_re_o,
  output logic [CLUT_AW-1:0] clut_addr_o,
  input  logic [PIX_W-1:0]   clut_data_i,
  output logic               out_valid_o,
  output logic [PIX_W-1:0]   pix_o,
  output logic               cfg_err_o
);
  argb_t             s0_pix;
  logic              s0_idx, s0_own, s0_noa, s0_err;
  logic [CLUT_AW-1:0] s0_addr;

  pix_unpack u_unpack (
    .word_i(word_i), .sub_i(sub_i), .cmode_i(cmode_i), .fix_rgb_i(fix_rgb_i),
    .pix_o(s0_pix), .idx_use_o(s0_idx), .idx_o(s0_addr), .own_alpha_o(s0_own),
    .no_alpha_o(s0_noa), .err_o(s0_err)
  );

  assign clut_re_o   = in_valid_i & s0_idx;
  assign clut_addr_o = s0_addr;

  // stage 1: aligned with CLUT read data
  logic            v1_q, err1_q, idx1_q, own1_q, noa1_q, c24_q;
  argb_t           pix1_q;
  logic [1:0]      am1_q;
  logic [CH_W-1:0] fa1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0; err1_q <= 1'b0; idx1_q <= 1'b0; own1_q <= 1'b0;
      noa1_q <= 1'b0; c24_q <= 1'b0; pix1_q <= '0; am1_q <= '0; fa1_q <= '0;
    end else begin
      v1_q <= in_valid_i;
      if (in_valid_i) begin
        err1_q <= s0_err;
        idx1_q <= s0_idx;
        own1_q <= s0_own;
        noa1_q <= s0_noa & (~s0_idx | clut_24b_i);
        c24_q  <= clut_24b_i;
        pix1_q <= s0_pix;
        am1_q  <= amode_i;
        fa1_q  <= fix_alpha_i;
      end
    end
  end

  argb_t merged, moded;
  always_comb begin
    merged = pix1_q;
    if (idx1_q) begin
      merged = clut_data_i;
      if (own1_q)     merged.a = pix1_q.a;
      else if (c24_q) merged.a = 8'hff;
    end
  end

  pix_alpha u_alpha (.pix_i(merged), .amode_i(am1_q), .fix_alpha_i(fa1_q), .pix_o(moded));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      pix_o       <= '0;
      cfg_err_o   <= 1'b0;
    end else begin
      out_valid_o <= v1_q;
      if (v1_q) begin
        pix_o     <= err1_q ? '0 : moded;
        cfg_err_o <= err1_q;
      end else begin
        cfg_err_o <= 1'b0;
      end
    end
  end

  AST_STAGE1_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni) in_valid_i |=> v1_q); // R10
  AST_OUT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni) v1_q |=> out_valid_o); // R10
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni) !v1_q |=> !out_valid_o); // R10
  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) cfg_err_o |-> (out_valid_o && pix_o == '0)); // R1
  AST_OPAQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && noa1_q && !err1_q && am1_q == AM_KEEP) |=> pix_o[31:24] == 8'hff); // R3
  AST_FIXED_ALPHA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && !err1_q && am1_q == AM_FIXED) |=> pix_o[31:24] == $past(fa1_q)); // R8
  AST_SCALE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q && !err1_q && am1_q == AM_SCALE) |=> pix_o[31:24] <= $past(fa1_q)); // R8
endmodule

// File: tb/pix_expand_test.sv
module pix_expand_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] word = '0;
  logic [2:0]  sub = '0;
  logic [3:0]  cmode = '0;
  logic [1:0]  amode = '0;
  logic [7:0]  fa = '0;
  logic [23:0] frgb = '0;
  logic        c24 = 1'b0;
  logic        clut_re;
  logic [7:0]  clut_addr;
  logic [31:0] clut_data;
  logic        out_valid, cfg_err;
  logic [31:0] pix;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] clut_mem [256];
  logic [32:0] exp_q [$];
  int          due_q [$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pix_expand uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .word_i(word), .sub_i(sub),
    .cmode_i(cmode), .amode_i(amode), .fix_alpha_i(fa), .fix_rgb_i(frgb), .clut_24b_i(c24),
    .clut_re_o(clut_re), .clut_addr_o(clut_addr), .clut_data_i(clut_data),
    .out_valid_o(out_valid), .pix_o(pix), .cfg_err_o(cfg_err)
  );

  initial for (int i = 0; i < 256; i++)
    clut_mem[i] = {8'(i * 7 + 3), 8'(i ^ 8'ha5), 8'(i * 3), 8'(255 - i)};

  always @(posedge clk) if (clut_re) clut_data <= clut_mem[clut_addr];

  task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic [32:0] ref_px(logic [31:0] w, int s, int cm, int am, int fx,
                                          logic [23:0] rgb, bit t24);
    int a, r, g, b, idx, hw, by, nb, v;
    bit ind, own;
    logic [31:0] e;
    hw = (s % 2 == 1) ? int'(w[31:16]) : int'(w[15:0]);
    by = int'((w >> (8 * (s % 4))) & 32'hff);
    nb = int'((w >> (4 * s)) & 32'hf);
    ind = 0; own = 0; idx = 0;
    a = 255; r = 0; g = 0; b = 0;
    case (cm)
      0: begin a = int'(w[31:24]); r = int'(w[23:16]); g = int'(w[15:8]); b = int'(w[7:0]); end
      1: begin r = int'(w[23:16]); g = int'(w[15:8]); b = int'(w[7:0]); end
      2: begin
        v = (hw >> 11) & 31; r = v * 8 + v / 4;
        v = (hw >> 5) & 63;  g = v * 4 + v / 16;
        v = hw & 31;         b = v * 8 + v / 4;
      end
      3: begin
        a = ((hw >> 15) & 1) != 0 ? 255 : 0;
        v = (hw >> 10) & 31; r = v * 8 + v / 4;
        v = (hw >> 5) & 31;  g = v * 8 + v / 4;
        v = hw & 31;         b = v * 8 + v / 4;
      end
      4: begin a = ((hw >> 12) & 15) * 17; r = ((hw >> 8) & 15) * 17; g = ((hw >> 4) & 15) * 17; b = (hw & 15) * 17; end
      5: begin ind = 1; idx = by; end
      6: begin ind = 1; own = 1; idx = by & 15; a = (by >> 4) * 17; end
      7: begin ind = 1; own = 1; idx = hw & 255; a = hw >> 8; end
      8: begin ind = 1; idx = nb; end
      9: begin a = by; r = int'(rgb[23:16]); g = int'(rgb[15:8]); b = int'(rgb[7:0]); end
      10: begin a = nb * 17; r = int'(rgb[23:16]); g = int'(rgb[15:8]); b = int'(rgb[7:0]); end
      default: return {1'b1, 32'h0};
    endcase
    if (ind) begin
      e = clut_mem[idx];
      r = int'(e[23:16]); g = int'(e[15:8]); b = int'(e[7:0]);
      if (!own) a = t24 ? 255 : int'(e[31:24]);
    end
    if (am == 1) a = fx;
    else if (am == 2) a = (a * fx) / 255;
    return {1'b0, 8'(a), 8'(r), 8'(g), 8'(b)};
  endfunction

  task automatic send(input logic [31:0] w, input int s, input int cm, input int am,
                      input int fx, input logic [23:0] rgb, input bit t24);
    bit idx_fmt;
    int ea;
    word = w; sub = 3'(s); cmode = 4'(cm); amode = 2'(am); fa = 8'(fx); frgb = rgb; c24 = t24;
    in_valid = 1'b1;
    exp_q.push_back(ref_px(w, s, cm, am, fx, rgb, t24));
    due_q.push_back(cyc + 2);
    #1;
    idx_fmt = (cm >= 5 && cm <= 8);
    case (cm)
      5: ea = int'((w >> (8 * (s % 4))) & 32'hff);
      6: ea = int'((w >> (8 * (s % 4))) & 32'hf);
      7: ea = (s % 2 == 1) ? int'(w[23:16]) : int'(w[7:0]);
      8: ea = int'((w >> (4 * s)) & 32'hf);
      default: ea = 0;
    endcase
    // R4: read only for indexed formats, with luminance index
    check(clut_re == idx_fmt && (!idx_fmt || clut_addr == 8'(ea)), "R4",
          {24'd0, clut_re, clut_addr}, {24'd0, idx_fmt, 8'(ea)});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R10", {1'b0, pix}, '0);
      else begin
        logic [32:0] ex;
        int d;
        ex = exp_q.pop_front();
        d = due_q.pop_front();
        check(d == cyc, "R10", 33'(cyc), 33'(d));
        check({cfg_err, pix} == ex, "R1-R9 pixel", {cfg_err, pix}, ex);
      end
    end else if (due_q.size() != 0 && due_q[0] <= cyc) begin
      check(1'b0, "R10", 33'(cyc), 33'(due_q[0]));
      void'(exp_q.pop_front());
      void'(due_q.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !cfg_err && !clut_re && pix == 0, "reset",
          {cfg_err, pix}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 direct formats and widening
    send(32'h80_12_34_56, 0, 0, 0, 0, 0, 0);
    send(32'h00_ab_cd_ef, 0, 1, 0, 0, 0, 0);          // R3 RGB888 opaque
    send(32'h0000_f81f, 0, 2, 0, 0, 0, 0);            // R2 RGB565 extremes
    send(32'h7c1f_0000, 1, 2, 0, 0, 0, 0);            // R9 upper half
    send(32'h0000_8421, 0, 3, 0, 0, 0, 0);            // R2 ARGB1555
    send(32'h7fff_0000, 1, 3, 0, 0, 0, 0);
    send(32'ha5c3_0000, 1, 4, 0, 0, 0, 0);            // R2 ARGB4444
    // R4 R5 indexed
    send(32'h11_22_33_44, 2, 5, 0, 0, 0, 0);          // R5 32-bit CLUT alpha
    send(32'h11_22_33_44, 3, 5, 0, 0, 0, 1);          // R5 24-bit CLUT -> FF
    send(32'h00_00_9c_00, 1, 6, 0, 0, 0, 1);          // R6 AL44 alpha override
    send(32'h3c_7e_00_00, 1, 7, 0, 0, 0, 0);          // R6 AL88
    send(32'h9000_0000, 7, 8, 0, 0, 0, 0);            // R9 top nibble L4
    send(32'h0000_000f, 0, 8, 0, 0, 0, 1);
    // R7 alpha only
    send(32'h00_5a_00_00, 2, 9, 0, 0, 24'h102030, 0);
    send(32'h0000_0b00, 2, 10, 0, 0, 24'hfedcba, 0);
    // R8 alpha modes
    send(32'hc0_01_02_03, 0, 0, 1, 8'h33, 0, 0);
    send(32'hc0_01_02_03, 0, 0, 2, 8'h80, 0, 0);
    send(32'hff_01_02_03, 0, 0, 2, 8'hff, 0, 0);
    send(32'h01_01_02_03, 0, 0, 2, 8'hfe, 0, 0);
    send(32'hc0_01_02_03, 0, 0, 3, 8'h80, 0, 0);
    // R1 invalid codes
    for (int c = 11; c < 16; c++) send(32'hdead_beef, 0, c, 1, 8'h44, 0, 0);
    // R10 back-to-back random run with gaps
    for (int n = 0; n < 2000; n++) begin
      word = '0;
      if ($urandom_range(0, 3) == 0) @(negedge clk);
      fork begin
        logic [31:0] w;
        w = $urandom;
        // back-to-back: send drives and advances one cycle
        send(w, $urandom_range(0, 7), $urandom_range(0, 15), $urandom_range(0, 3),
             $urandom_range(0, 255), 24'($urandom), 1'($urandom));
      end join
    end
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R10 drain", 33'(exp_q.size()), 33'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule